// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block computes everything a processor core needs at the moment it takes an exception into a given privilege level. A one-cycle request carries the exception class, the level being entered, the level being left, the stack-select bit in force, whether the interrupted code ran in the 64-bit or the 32-bit execution state, whether 32-bit code used the compact instruction encoding, and the syndrome, fault address, program counter and status word of the interrupted context.

One cycle later the block presents the handler address, the new status word and a set of write strobes with data for the target level's link, saved-status, syndrome and fault-address registers. The handler address is the target level's vector base plus two offsets. The first offset depends on where the exception came from. The second depends on whether it is synchronous, an IRQ or an FIQ.

The block holds one vector base register per level. These registers are loaded through a simple write port, and they take part in every address the block computes.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `entry_done`, all four write strobes, `new_pc` and every vector base register are zero.
- R2: When `cur_lvl` is below `req_tgt_lvl`, the origin offset is 0x400 if `cur_is64` is 1 and 0x600 if `cur_is64` is 0.
- R3: When `cur_lvl` equals `req_tgt_lvl`, the origin offset is 0x200 if `cur_sp_sel` is 1 and 0 if it is 0. When `cur_lvl` is above `req_tgt_lvl`, the origin offset is 0.
- R4: The class code is 4 bits: 0 breakpoint, 1 undefined, 2 supervisor call, 3 hypervisor call, 4 trap, 5 secure call, 6 instruction abort, 7 data abort, 8 IRQ, 9 virtual IRQ, 10 FIQ, 11 virtual FIQ. Classes 8 and 9 add 0x80 to the handler address, classes 10 and 11 add 0x100, and classes 0 to 7 add nothing. `new_pc` is the vector base of the target level plus the origin offset plus this offset.
- R5: A write through `vbar_we`/`vbar_sel`/`vbar_wdata` stores the data with bits [10:0] forced to zero. The stored value is used by every later entry to that level.
- R6: On every accepted entry, `link_we` and `sstat_we` pulse, `link_data` equals the request's `cur_pc`, and `sstat_data` equals its `cur_status`.
- R7: Classes 0 to 7 pulse `synd_we`. Only classes 6 and 7 also pulse `fault_we`, and then `fault_data` carries `req_fault_addr`. Classes 8 to 11 pulse neither strobe.
- R8: `synd_data` equals `req_syndrome` with bit 25 forced to 1 when `cur_is64` is 0 and `cur_compact` is 0. Otherwise it equals `req_syndrome` unchanged.
- R9: `new_status` has bit 0 (stack select) set to 1, bit 1 cleared, bits [3:2] equal to the target level, bit 4 (execution state, 1 = 32-bit) cleared, bits [8:5] (the four interrupt masks) all set, and every higher bit cleared.
- R10: A request sampled at one rising edge produces `entry_done`, the strobes and the data at the next edge. The strobes are high for exactly one cycle, and `wr_lvl` equals the target level.
- R11: A request with a class code from 12 to 15 is ignored. No strobe or `entry_done` pulses, and `new_pc` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle exception request strobe |
| req_class | input | 4 | Exception class code |
| req_tgt_lvl | input | 2 | Level being entered |
| cur_lvl | input | 2 | Level being left |
| cur_sp_sel | input | 1 | Dedicated stack selected in the interrupted context |
| cur_is64 | input | 1 | Interrupted code in 64-bit execution state |
| cur_compact | input | 1 | 32-bit code in compact encoding |
| req_syndrome | input | 32 | Syndrome value for synchronous classes |
| req_fault_addr | input | 64 | Faulting address for aborts |
| cur_pc | input | 64 | Program counter of the interrupted code |
| cur_status | input | 32 | Status word of the interrupted code |
| vbar_we | input | 1 | Vector base write enable |
| vbar_sel | input | 2 | Vector base register select |
| vbar_wdata | input | 64 | Vector base write data |
| entry_done | output | 1 | Entry outputs valid this cycle |
| wr_lvl | output | 2 | Level whose registers are written |
| new_pc | output | 64 | Handler address |
| new_status | output | 32 | Status word for the handler |
| link_we | output | 1 | Link register write strobe |
| link_data | output | 64 | Link register data |
| sstat_we | output | 1 | Saved-status register write strobe |
| sstat_data | output | 32 | Saved-status register data |
| synd_we | output | 1 | Syndrome register write strobe |
| synd_data | output | 32 | Syndrome register data |
| fault_we | output | 1 | Fault-address register write strobe |
| fault_data | output | 64 | Fault-address register data |

## Verification
The assertions assume that `req_valid` is never high on two consecutive cycles. They also assume that the interrupted context's inputs stay stable only during the cycle the request is sampled, so each `$past` comparison refers to that single request. The stimulus follows this by raising `req_valid` for one cycle and then idling it for at least one cycle while the result is checked. Vector base writes happen only between requests, never in the same cycle as one. The class codes are drawn over the full 4-bit range, so the reserved codes are exercised too. Level pairs are drawn freely, so entries from a higher level also occur.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CLS_W     = 4;
  localparam int VEC_OFF_W = 11;   // low vector-base bits reserved for offsets

  localparam logic [CLS_W-1:0] CLS_IABT  = 4'd6;
  localparam logic [CLS_W-1:0] CLS_DABT  = 4'd7;
  localparam logic [CLS_W-1:0] CLS_IRQ   = 4'd8;
  localparam logic [CLS_W-1:0] CLS_VIRQ  = 4'd9;
  localparam logic [CLS_W-1:0] CLS_FIQ   = 4'd10;
  localparam logic [CLS_W-1:0] CLS_VFIQ  = 4'd11;

  typedef enum logic [1:0] {
    ORG_FAR_SP   = 2'd0,  // same level or from above, no dedicated stack
    ORG_SAME_SP  = 2'd1,
    ORG_LOW_64   = 2'd2,
    ORG_LOW_32   = 2'd3
  } origin_e;

  function automatic logic cls_known(input logic [CLS_W-1:0] c);
    return c <= CLS_VFIQ;
  endfunction

  function automatic logic cls_sync(input logic [CLS_W-1:0] c);
    return c < CLS_IRQ;
  endfunction

  function automatic logic cls_abort(input logic [CLS_W-1:0] c);
    return (c == CLS_IABT) || (c == CLS_DABT);
  endfunction

  function automatic logic [VEC_OFF_W-1:0] origin_offset(input origin_e o);
    case (o)
      ORG_LOW_64:  return 11'h400;
      ORG_LOW_32:  return 11'h600;
      ORG_SAME_SP: return 11'h200;
      default:     return 11'h000;
    endcase
  endfunction

  function automatic logic [VEC_OFF_W-1:0] type_offset(input logic [CLS_W-1:0] c);
    if ((c == CLS_IRQ) || (c == CLS_VIRQ)) return 11'h080;
    if ((c == CLS_FIQ) || (c == CLS_VFIQ)) return 11'h100;
    return 11'h000;
  endfunction

endpackage

// File: rtl/exc_vbar_bank.sv
module exc_vbar_bank #(
  parameter int ADDR_W  = 64,
  parameter int NUM_LVL = 4,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LVL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [LVL_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_data
);
  import exc_entry_pkg::*;

  logic [ADDR_W-1:0] base_q [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= '0;
      end else if (wr_en && (wr_sel == LVL_W'(g))) begin
        base_q[g] <= {wr_data[ADDR_W-1:VEC_OFF_W], {VEC_OFF_W{1'b0}}};
      end
    end
  end

  assign rd_data = base_q[rd_sel];
endmodule

// File: rtl/exc_vec_offset.sv
module exc_vec_offset #(
  parameter int NUM_LVL = 4,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic [exc_entry_pkg::CLS_W-1:0]     cls,
  input  logic [LVL_W-1:0]                    tgt_lvl,
  input  logic [LVL_W-1:0]                    src_lvl,
  input  logic                                sp_sel,
  input  logic                                src_is64,
  output exc_entry_pkg::origin_e              origin,
  output logic [exc_entry_pkg::VEC_OFF_W-1:0] offset
);
  import exc_entry_pkg::*;

  logic from_below;
  logic same_lvl;

  assign from_below = src_lvl < tgt_lvl;
  assign same_lvl   = src_lvl == tgt_lvl;

  always_comb begin
    if (from_below)          origin = src_is64 ? ORG_LOW_64 : ORG_LOW_32;
    else if (same_lvl && sp_sel) origin = ORG_SAME_SP;
    else                     origin = ORG_FAR_SP;
  end

  assign offset = origin_offset(origin) + type_offset(cls);
endmodule

// File: rtl/exc_state_build.sv
module exc_state_build #(
  parameter int NUM_LVL  = 4,
  parameter int STATUS_W = 32,
  parameter int SYN_W    = 32,
  localparam int LVL_W   = $clog2(NUM_LVL),
  localparam int EXEC_BIT = LVL_W + 2,
  localparam int MASK_LSB = LVL_W + 3
) (
  input  logic [exc_entry_pkg::CLS_W-1:0] cls,
  input  logic [LVL_W-1:0]                tgt_lvl,
  input  logic                            src_is64,
  input  logic                            src_compact,
  input  logic [SYN_W-1:0]                syndrome,
  output logic [STATUS_W-1:0]             status_out,
  output logic [SYN_W-1:0]                synd_out,
  output logic                            synd_en,
  output logic                            fault_en
);
  import exc_entry_pkg::*;

  localparam int WIDE_BIT = 25;

  always_comb begin
    status_out = '0;
    status_out[0] = 1'b1;
    status_out[LVL_W+1:2] = tgt_lvl;
    status_out[EXEC_BIT] = 1'b0;
    status_out[MASK_LSB+3:MASK_LSB] = 4'hF;
  end

  always_comb begin
    synd_out = syndrome;
    if (!src_is64 && !src_compact) synd_out[WIDE_BIT] = 1'b1;
  end

  assign synd_en  = cls_sync(cls);
  assign fault_en = cls_abort(cls);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int ADDR_W   = 64,
  parameter int NUM_LVL  = 4,
  parameter int STATUS_W = 32,
  parameter int SYN_W    = 32,
  localparam int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [3:0]          req_class,
  input  logic [LVL_W-1:0]    req_tgt_lvl,
  input  logic [LVL_W-1:0]    cur_lvl,
  input  logic                cur_sp_sel,
  input  logic                cur_is64,
  input  logic                cur_compact,
  input  logic [SYN_W-1:0]    req_syndrome,
  input  logic [ADDR_W-1:0]   req_fault_addr,
  input  logic [ADDR_W-1:0]   cur_pc,
  input  logic [STATUS_W-1:0] cur_status,
  input  logic                vbar_we,
  input  logic [LVL_W-1:0]    vbar_sel,
  input  logic [ADDR_W-1:0]   vbar_wdata,
  output logic                entry_done,
  output logic [LVL_W-1:0]    wr_lvl,
  output logic [ADDR_W-1:0]   new_pc,
  output logic [STATUS_W-1:0] new_status,
  output logic                link_we,
  output logic [ADDR_W-1:0]   link_data,
  output logic                sstat_we,
  output logic [STATUS_W-1:0] sstat_data,
  output logic                synd_we,
  output logic [SYN_W-1:0]    synd_data,
  output logic                fault_we,
  output logic [ADDR_W-1:0]   fault_data
);
  import exc_entry_pkg::*;

  logic [ADDR_W-1:0]    base_sel;
  origin_e              origin;
  logic [VEC_OFF_W-1:0] vec_off;
  logic [STATUS_W-1:0]  status_nxt;
  logic [SYN_W-1:0]     synd_nxt;
  logic                 synd_en;
  logic                 fault_en;
  logic                 accept;

  assign accept = req_valid && cls_known(req_class);

  exc_vbar_bank #(.ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL)) vbar_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(vbar_we), .wr_sel(vbar_sel), .wr_data(vbar_wdata),
    .rd_sel(req_tgt_lvl), .rd_data(base_sel)
  );

  exc_vec_offset #(.NUM_LVL(NUM_LVL)) off_i (
    .cls(req_class), .tgt_lvl(req_tgt_lvl), .src_lvl(cur_lvl),
    .sp_sel(cur_sp_sel), .src_is64(cur_is64),
    .origin(origin), .offset(vec_off)
  );

  exc_state_build #(.NUM_LVL(NUM_LVL), .STATUS_W(STATUS_W), .SYN_W(SYN_W)) st_i (
    .cls(req_class), .tgt_lvl(req_tgt_lvl), .src_is64(cur_is64),
    .src_compact(cur_compact), .syndrome(req_syndrome),
    .status_out(status_nxt), .synd_out(synd_nxt),
    .synd_en(synd_en), .fault_en(fault_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_done <= 1'b0;
      link_we    <= 1'b0;
      sstat_we   <= 1'b0;
      synd_we    <= 1'b0;
      fault_we   <= 1'b0;
      wr_lvl     <= '0;
      new_pc     <= '0;
      new_status <= '0;
      link_data  <= '0;
      sstat_data <= '0;
      synd_data  <= '0;
      fault_data <= '0;
    end else begin
      entry_done <= accept;
      link_we    <= accept;
      sstat_we   <= accept;
      synd_we    <= accept && synd_en;
      fault_we   <= accept && fault_en;
      if (accept) begin
        wr_lvl     <= req_tgt_lvl;
        new_pc     <= base_sel + ADDR_W'(vec_off);
        new_status <= status_nxt;
        link_data  <= cur_pc;
        sstat_data <= cur_status;
        synd_data  <= synd_nxt;
        fault_data <= req_fault_addr;
      end
    end
  end

  // origin is kept as a named internal event for debug visibility
  logic origin_low;
  assign origin_low = (origin == ORG_LOW_64) || (origin == ORG_LOW_32);
  logic unused_ok;
  assign unused_ok = origin_low;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int ADDR_W   = 64,
  parameter int STATUS_W = 32,
  parameter int LVL_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [3:0]          req_class,
  input logic [LVL_W-1:0]    req_tgt_lvl,
  input logic [ADDR_W-1:0]   cur_pc,
  input logic [STATUS_W-1:0] cur_status,
  input logic                entry_done,
  input logic [LVL_W-1:0]    wr_lvl,
  input logic [ADDR_W-1:0]   new_pc,
  input logic [STATUS_W-1:0] new_status,
  input logic                link_we,
  input logic [ADDR_W-1:0]   link_data,
  input logic                sstat_we,
  input logic [STATUS_W-1:0] sstat_data,
  input logic                synd_we,
  input logic                fault_we
);
  localparam int MASK_LSB = LVL_W + 3;

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> $past(req_valid));

  assert_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> wr_lvl == $past(req_tgt_lvl));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_done |-> !link_we && !sstat_we && !synd_we && !fault_we);

  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class > 4'd11) |=> !entry_done && $stable(new_pc));

  assert_fault_synd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_we |-> synd_we);

  assert_irq_no_synd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class >= 4'd8) |=> !synd_we && !fault_we);

  assert_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> link_we && sstat_we && link_data == $past(cur_pc)
                   && sstat_data == $past(cur_status));

  assert_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> new_status[0] && !new_status[LVL_W+2]
                   && (&new_status[MASK_LSB+3:MASK_LSB]));

  assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> new_pc[6:0] == 7'd0);
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .ADDR_W(ADDR_W), .STATUS_W(STATUS_W), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
  .req_tgt_lvl(req_tgt_lvl), .cur_pc(cur_pc), .cur_status(cur_status),
  .entry_done(entry_done), .wr_lvl(wr_lvl), .new_pc(new_pc),
  .new_status(new_status), .link_we(link_we), .link_data(link_data),
  .sstat_we(sstat_we), .sstat_data(sstat_data), .synd_we(synd_we),
  .fault_we(fault_we)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_class;
  logic [1:0]  req_tgt_lvl, cur_lvl;
  logic        cur_sp_sel, cur_is64, cur_compact;
  logic [31:0] req_syndrome;
  logic [63:0] req_fault_addr, cur_pc;
  logic [31:0] cur_status;
  logic        vbar_we;
  logic [1:0]  vbar_sel;
  logic [63:0] vbar_wdata;
  logic        entry_done;
  logic [1:0]  wr_lvl;
  logic [63:0] new_pc;
  logic [31:0] new_status;
  logic        link_we, sstat_we, synd_we, fault_we;
  logic [63:0] link_data, fault_data;
  logic [31:0] sstat_data, synd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [63:0] vb_model [4];
  logic [63:0] last_pc;

  always #2 clk = ~clk;

  exc_entry_ctrl dut_i (.*);

  function automatic logic [63:0] exp_pc(input logic [3:0] c, input logic [1:0] t,
      input logic [1:0] s, input logic sp, input logic w64);
    logic [63:0] o = 0;
    if (s < t) o = w64 ? 64'h400 : 64'h600;
    else if (s == t && sp) o = 64'h200;
    if (c == 8 || c == 9) o += 64'h80;
    if (c == 10 || c == 11) o += 64'h100;
    return vb_model[t] + o;
  endfunction

  function automatic logic [31:0] exp_status(input logic [1:0] t);
    return 32'h1E0 | {28'd0, t, 2'b01};
  endfunction

  function automatic logic [31:0] exp_synd(input logic [31:0] s, input logic w64,
      input logic cmp);
    return (!w64 && !cmp) ? (s | 32'h0200_0000) : s;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_vbar(input logic [1:0] l, input logic [63:0] d);
    @(negedge clk);
    vbar_we = 1; vbar_sel = l; vbar_wdata = d;
    @(negedge clk);
    vbar_we = 0;
    vb_model[l] = {d[63:11], 11'd0};
  endtask

  task automatic entry(input logic [3:0] c, input logic [1:0] t, input logic [1:0] s,
      input logic sp, input logic w64, input logic cmp);
    logic known, sync, abrt;
    @(negedge clk);
    req_valid = 1; req_class = c; req_tgt_lvl = t; cur_lvl = s;
    cur_sp_sel = sp; cur_is64 = w64; cur_compact = cmp;
    req_syndrome = $urandom; req_fault_addr = {$urandom, $urandom};
    cur_pc = {$urandom, $urandom}; cur_status = $urandom;
    @(negedge clk);
    req_valid = 0;
    known = c <= 11; sync = c <= 7; abrt = (c == 6 || c == 7);
    if (!known) begin
      chk("R11 done", {63'd0, entry_done}, 0);
      chk("R11 strobes", {60'd0, link_we, sstat_we, synd_we, fault_we}, 0);
      chk("R11 pc held", new_pc, last_pc);
    end else begin
      chk("R10 done", {63'd0, entry_done}, 1);
      chk("R10 wr_lvl", {62'd0, wr_lvl}, {62'd0, t});
      chk("R2/R3/R4 new_pc", new_pc, exp_pc(c, t, s, sp, w64));
      chk("R9 new_status", {32'd0, new_status}, {32'd0, exp_status(t)});
      chk("R6 link", link_data, cur_pc);
      chk("R6 sstat", {32'd0, sstat_data}, {32'd0, cur_status});
      chk("R6 strobes", {62'd0, link_we, sstat_we}, 3);
      chk("R7 synd_we", {63'd0, synd_we}, {63'd0, sync});
      chk("R7 fault_we", {63'd0, fault_we}, {63'd0, abrt});
      if (sync) chk("R8 synd_data", {32'd0, synd_data}, {32'd0, exp_synd(req_syndrome, w64, cmp)});
      if (abrt) chk("R7 fault_data", fault_data, req_fault_addr);
      last_pc = new_pc;
      @(negedge clk);
      chk("R10 one-cycle pulse", {59'd0, entry_done, link_we, sstat_we, synd_we, fault_we}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; req_valid = 0; req_class = 0; req_tgt_lvl = 0; cur_lvl = 0;
    cur_sp_sel = 0; cur_is64 = 0; cur_compact = 0; req_syndrome = 0;
    req_fault_addr = 0; cur_pc = 0; cur_status = 0;
    vbar_we = 0; vbar_sel = 0; vbar_wdata = 0;
    for (int i = 0; i < 4; i++) vb_model[i] = 0;
    last_pc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done", {63'd0, entry_done}, 0);
    chk("R1 strobes", {60'd0, link_we, sstat_we, synd_we, fault_we}, 0);
    chk("R1 new_pc", new_pc, 0);
    entry(4'd8, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0);   // R1: base zero
    chk("R1 vbar zero", new_pc, 64'h80);

    write_vbar(2'd1, 64'hFFFF_0000_1234_57FF); // R5 low bits dropped
    write_vbar(2'd2, 64'h0000_0000_8000_0800);
    write_vbar(2'd3, 64'h0000_0040_0000_0000);
    // R2: lower level, both states, with each type
    entry(4'd0, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0);
    chk("R2 low64 sync", new_pc, 64'h8000_0C00);
    entry(4'd10, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1);
    chk("R2 low32 fiq", new_pc, 64'h8000_0F00);
    // R3: same level with/without stack, and from above
    entry(4'd9, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0);
    chk("R3 same sp irq", new_pc, 64'hFFFF_0000_1234_5280);
    entry(4'd11, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0);
    chk("R5 R3 same nosp vfiq", new_pc, 64'hFFFF_0000_1234_5100);
    entry(4'd2, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0);
    chk("R3 from above", new_pc, 64'hFFFF_0000_1234_5000);
    // R7/R8 aborts, 32-bit non-compact and compact
    entry(4'd7, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0);
    entry(4'd6, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1);
    // R11 reserved codes
    entry(4'd12, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0);
    entry(4'd15, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0);

    for (int n = 0; n < 400; n++) begin
      if (($urandom % 8) == 0) write_vbar(2'($urandom), {$urandom, $urandom});
      entry(4'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule